// File: doc/BRIEF.md
# TDM Sample Frame Serializer

This block models the digital output stage of a multichannel data converter. It takes one 24-bit two's-complement word per channel, a mask of powered channels and a packing choice, and sends the words as a single time-division-multiplexed bit stream on one data line. The host supplies the shift clock. Each new bit is launched after a falling edge of that clock, so the receiver samples on the rising edge. The shift clock, the frame clock and the chain input are brought into the system clock domain by a synchronizer before edge detection.

Two packing styles are offered. In fixed-slot packing every channel keeps its own 24-bit slot, and the slot of a powered-down channel carries zeros. In compacting packing only the powered channels are sent, back to back, so the frame gets shorter. Two framing styles share the same pins. In strobe framing the block pulls an active-low ready output low when a frame is waiting, and the host then clocks it out. In frame-clock framing a rising edge on the frame-clock input starts each new frame. After the local bits, the bits taken from a chain input follow on the data line, so several blocks can be cascaded on one line.

A resynchronization pulse models the settling of the converter's filter. The ready output stays high and a configurable number of later sample loads are dropped. A frame loaded while the host is partway through reading the current frame is held back until the last local bit of the current frame has been shifted out.

Top module: `tdm_frame_tx`

## Requirements
- R1: After reset, dout_o is 0 and drdy_n_o is 1.
- R2: In strobe framing (frame_sync_mode_i = 0), drdy_n_o goes to 0 once an accepted frame is presented, and returns to 1 after the first falling edge of sclk_i.
- R3: Channel c occupies samples_i[24c+23:24c] (c = 0 is the first channel). Channels are sent in ascending order, each most-significant bit first. The first bit is valid before the first falling edge of sclk_i, and each falling edge advances the stream by exactly one bit.
- R4: With pack_dyn_i = 0, every channel has a 24-bit slot, and a channel whose chan_en_i bit is 0 sends 24 zero bits.
- R5: With pack_dyn_i = 1, only channels whose chan_en_i bit is 1 are sent, in ascending order with no gaps, and the local frame is 24 times the number of enabled channels long.
- R6: After the L local bits, the value seen on chain_i at falling edge j of sclk_i appears as stream bit L+j (counting from 1). With eight channels in fixed-slot packing, the first chained bit is bit 193.
- R7: In strobe framing, a frame loaded after the first bit of the current frame has been shifted, and before its last local bit has been shifted, is presented only after the last local bit has been shifted.
- R8: In frame-clock framing (frame_sync_mode_i = 1), a loaded frame waits until the next rising edge of fclk_i and then presents its first bit. drdy_n_o stays at 1 in this framing.
- R9: After a pulse on resync_i, drdy_n_o stays at 1 and the next SETTLE_FRAMES pulses of load_i are dropped. The pulse after those is accepted.
- R10: chan_en_i, pack_dyn_i and samples_i are captured when load_i is accepted. Changing them afterwards does not alter the frame being sent.
- R11: The full-scale codes 7FFFFFh and 800000h are sent unchanged, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| samples_i | input | NCH*24 | Channel words; channel c at bits 24c+23:24c |
| chan_en_i | input | NCH | Channel power mask, 1 = powered |
| pack_dyn_i | input | 1 | 0 = fixed-slot packing, 1 = compacting packing |
| frame_sync_mode_i | input | 1 | 0 = strobe framing, 1 = frame-clock framing |
| load_i | input | 1 | One-cycle pulse: new set of samples available |
| resync_i | input | 1 | One-cycle pulse: restart filter settling |
| sclk_i | input | 1 | Host shift clock; a bit advances on each falling edge |
| fclk_i | input | 1 | Frame clock; a rising edge starts a frame in frame-clock framing |
| chain_i | input | 1 | Serial data from the next device in the chain |
| dout_o | output | 1 | Serial TDM data |
| drdy_n_o | output | 1 | Active-low frame-ready strobe (strobe framing) |

## Verification
The bench builds the block with eight channels and SETTLE_FRAMES set to 4. Eight channels bring the chain boundary at bit 193 within reach, and the short settling window lets the whole drop-then-accept sequence after a resync run in a few loads. Random masks, packing choices and chain bit patterns run through both packing styles, including compact frames with a single channel. Directed cases cover full-scale codes, a load that arrives partway through a readback, a mask changed after load, and a frame that waits for the frame-clock edge.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

   localparam int unsigned WORD_W = 24;

   typedef enum logic {
      PACK_FIXED   = 1'b0,
      PACK_DYNAMIC = 1'b1
   } pack_mode_e;

   typedef enum logic {
      FRAMING_STROBE = 1'b0,
      FRAMING_FCLK   = 1'b1
   } framing_e;

endpackage

// File: rtl/tdm_pin_sync.sv
module tdm_pin_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] pins_i,
   output logic [WIDTH-1:0] pins_o
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("tdm_pin_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) stage_q[0] <= '0;
      else         stage_q[0] <= pins_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk_i) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign pins_o = stage_q[STAGES-1];

endmodule

// File: rtl/tdm_packer.sv
module tdm_packer import tdm_tx_pkg::*; #(
   parameter int unsigned NCH = 8
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic [NCH*WORD_W-1:0]        samples_i,
   input  logic [NCH-1:0]               chan_en_i,
   input  logic                         dynamic_i,
   output logic [NCH*WORD_W-1:0]        frame_o,
   output logic [$clog2(NCH+1)-1:0]     len_o
);

   localparam int unsigned LW = $clog2(NCH + 1);
   localparam int unsigned IW = $clog2(NCH);

   logic [WORD_W-1:0] words [NCH];
   logic [LW-1:0]     fill;
   logic [LW-1:0]     len_c;

   always_comb begin
      fill = '0;
      for (int i = 0; i < NCH; i++) words[i] = '0;
      for (int i = 0; i < NCH; i++) begin
         if (dynamic_i) begin
            if (chan_en_i[i]) begin
               words[fill[IW-1:0]] = samples_i[i*WORD_W +: WORD_W];
               fill = fill + 1'b1;
            end
         end else begin
            words[i] = chan_en_i[i] ? samples_i[i*WORD_W +: WORD_W] : '0;
         end
      end
      len_c = dynamic_i ? fill : LW'(NCH);
      frame_o = '0;
      for (int s = 0; s < NCH; s++) begin
         if (s < int'(len_c)) frame_o[(int'(len_c) - 1 - s)*WORD_W +: WORD_W] = words[s];
      end
   end

   assign len_o = len_c;

   AST_LEN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(len_o) == (dynamic_i ? $countones(chan_en_i) : NCH)); // R5

endmodule

// File: rtl/tdm_shifter.sv
module tdm_shifter import tdm_tx_pkg::*; #(
   parameter int unsigned NCH = 8
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      load_i,
   input  logic [NCH*WORD_W-1:0]     frame_i,
   input  logic [$clog2(NCH+1)-1:0]  len_i,
   input  logic                      shift_i,
   input  logic                      chain_i,
   output logic                      dout_o,
   output logic                      busy_o
);

   localparam int unsigned W  = NCH * WORD_W;
   localparam int unsigned LW = $clog2(NCH + 1);
   localparam int unsigned CW = $clog2(W + 1);

   logic [W-1:0]  sreg_q;
   logic [LW-1:0] len_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] bits;
   logic [CW-1:0] tap;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sreg_q <= '0;
         len_q  <= LW'(NCH);
         cnt_q  <= '0;
      end else if (load_i) begin
         sreg_q <= frame_i;
         len_q  <= len_i;
         cnt_q  <= '0;
      end else if (shift_i) begin
         sreg_q <= {sreg_q[W-2:0], chain_i};
         if (cnt_q < CW'(W)) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign bits   = CW'(len_q) * CW'(WORD_W);
   assign tap    = (len_q == '0) ? '0 : bits - 1'b1;
   assign dout_o = (len_q == '0) ? chain_i : sreg_q[tap];
   assign busy_o = (cnt_q != '0) && (cnt_q < bits);

   AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_i && !load_i && cnt_q < CW'(W)) |=> cnt_q == $past(cnt_q) + 1'b1); // R3
   AST_LOAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (cnt_q == '0) && !busy_o); // R7
   AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!shift_i && !load_i && len_q != '0) |=> $stable(dout_o)); // R3

endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx import tdm_tx_pkg::*; #(
   parameter int unsigned NCH           = 8,
   parameter int unsigned SETTLE_FRAMES = 128,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NCH*24-1:0]     samples_i,
   input  logic [NCH-1:0]        chan_en_i,
   input  logic                  pack_dyn_i,
   input  logic                  frame_sync_mode_i,
   input  logic                  load_i,
   input  logic                  resync_i,
   input  logic                  sclk_i,
   input  logic                  fclk_i,
   input  logic                  chain_i,
   output logic                  dout_o,
   output logic                  drdy_n_o
);

   localparam int unsigned W  = NCH * WORD_W;
   localparam int unsigned LW = $clog2(NCH + 1);
   localparam int unsigned SW = $clog2(SETTLE_FRAMES + 1);

   generate
      if (!(NCH == 4 || NCH == 8)) begin : g_bad_nch
         $error("tdm_frame_tx: NCH must be 4 or 8");
      end
      if (SETTLE_FRAMES < 1) begin : g_bad_settle
         $error("tdm_frame_tx: SETTLE_FRAMES must be at least 1");
      end
   endgenerate

   pack_mode_e pack_mode;
   framing_e   framing;
   assign pack_mode = pack_mode_e'(pack_dyn_i);
   assign framing   = framing_e'(frame_sync_mode_i);

   // Pin synchronizer: bit 2 frame clock, bit 1 chain data, bit 0 shift clock
   logic [2:0] pin_lvl;
   logic       sclk_prev_q, fclk_prev_q;
   logic       sclk_fall, fclk_rise;

   tdm_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pins_i ({fclk_i, chain_i, sclk_i}),
      .pins_o (pin_lvl)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sclk_prev_q <= 1'b0;
         fclk_prev_q <= 1'b0;
      end else begin
         sclk_prev_q <= pin_lvl[0];
         fclk_prev_q <= pin_lvl[2];
      end
   end

   assign sclk_fall = sclk_prev_q & ~pin_lvl[0];
   assign fclk_rise = pin_lvl[2] & ~fclk_prev_q;

   // Packing of the sample set offered at load time
   logic [W-1:0]  pk_frame;
   logic [LW-1:0] pk_len;

   tdm_packer #(.NCH(NCH)) u_pack (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .samples_i (samples_i),
      .chan_en_i (chan_en_i),
      .dynamic_i (pack_mode == PACK_DYNAMIC),
      .frame_o   (pk_frame),
      .len_o     (pk_len)
   );

   // Settling window, staged frame and ready strobe
   logic [SW-1:0] settle_q;
   logic          pend_v_q;
   logic [W-1:0]  pend_frame_q;
   logic [LW-1:0] pend_len_q;
   logic          rdy_n_q;
   logic          accept, xfer, sh_busy;

   assign accept = load_i && (settle_q == '0) && !resync_i;
   assign xfer   = pend_v_q && ((framing == FRAMING_FCLK) ? fclk_rise : !sh_busy);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         settle_q <= '0;
      end else if (resync_i) begin
         settle_q <= SW'(SETTLE_FRAMES);
      end else if (load_i && settle_q != '0) begin
         settle_q <= settle_q - 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_v_q     <= 1'b0;
         pend_frame_q <= '0;
         pend_len_q   <= '0;
      end else if (resync_i) begin
         pend_v_q <= 1'b0;
      end else if (accept) begin
         pend_v_q     <= 1'b1;
         pend_frame_q <= pk_frame;
         pend_len_q   <= pk_len;
      end else if (xfer) begin
         pend_v_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                              rdy_n_q <= 1'b1;
      else if (resync_i)                        rdy_n_q <= 1'b1;
      else if (xfer && framing == FRAMING_STROBE) rdy_n_q <= 1'b0;
      else if (sclk_fall)                       rdy_n_q <= 1'b1;
   end

   assign drdy_n_o = (framing == FRAMING_FCLK) ? 1'b1 : rdy_n_q;

   tdm_shifter #(.NCH(NCH)) u_shift (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (xfer),
      .frame_i (pend_frame_q),
      .len_i   (pend_len_q),
      .shift_i (sclk_fall),
      .chain_i (pin_lvl[1]),
      .dout_o  (dout_o),
      .busy_o  (sh_busy)
   );

   AST_DRDY_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settle_q != '0) |-> drdy_n_o); // R9
   AST_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_v_q && sh_busy && !frame_sync_mode_i && !resync_i) |=> pend_v_q); // R7
   AST_DRDY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!frame_sync_mode_i && xfer && !sclk_fall && !resync_i)
      |=> (frame_sync_mode_i || !drdy_n_o)); // R2

endmodule

// File: tb/test_tdm_frame_tx.sv
module test_tdm_frame_tx;

   localparam int unsigned CLK_P  = 10;
   localparam int unsigned NCH    = 8;
   localparam int unsigned SETTLE = 4;
   localparam int unsigned W      = NCH * 24;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [W-1:0]      samples = '0;
   logic [NCH-1:0]    chan_en = '1;
   logic              pack_dyn = 1'b0;
   logic              fs_mode = 1'b0;
   logic              load = 1'b0;
   logic              resync = 1'b0;
   logic              sclk = 1'b0;
   logic              fclk = 1'b0;
   logic              chain = 1'b0;
   logic              dout;
   logic              drdy_n;

   int checks = 0;
   int errors = 0;

   logic [W-1:0] cur_st;
   int           cur_len;
   logic         dz [0:511];

   tdm_frame_tx #(.NCH(NCH), .SETTLE_FRAMES(SETTLE), .SYNC_STAGES(2)) i_tdm_frame_tx (
      .clk_i(clk), .rst_ni(rst_n), .samples_i(samples), .chan_en_i(chan_en),
      .pack_dyn_i(pack_dyn), .frame_sync_mode_i(fs_mode), .load_i(load),
      .resync_i(resync), .sclk_i(sclk), .fclk_i(fclk), .chain_i(chain),
      .dout_o(dout), .drdy_n_o(drdy_n)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Expected stream: bit k of the frame at cur_st[W-1-k]
   function automatic void build(input logic [W-1:0] samp, input logic [NCH-1:0] en,
                                 input logic dyn, output logic [W-1:0] st, output int len);
      int pos = 0;
      st = '0;
      for (int c = 0; c < NCH; c++) begin
         if (!dyn || en[c]) begin
            for (int b = 23; b >= 0; b--) begin
               st[W-1-pos] = en[c] ? samp[c*24+b] : 1'b0;
               pos++;
            end
         end
      end
      len = pos;
   endfunction

   task automatic new_daisy();
      for (int i = 0; i < 512; i++) dz[i] = 1'($urandom);
   endtask

   task automatic do_load(input logic [W-1:0] s, input logic [NCH-1:0] en, input logic dyn);
      @(negedge clk);
      samples = s; chan_en = en; pack_dyn = dyn; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic clk_bit(input logic dbit, input logic raise_fs, output logic seen);
      @(negedge clk);
      seen = dout;
      sclk = 1'b1; fclk = 1'b0;
      repeat (2) @(negedge clk);
      chain = dbit;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      if (raise_fs) fclk = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic read_range(input int k0, input int k1, input string req);
      logic seen;
      logic exp;
      for (int k = k0; k < k1; k++) begin
         exp = (k < cur_len) ? cur_st[W-1-k] : dz[k-cur_len+1];
         clk_bit(dz[k+1], 1'b0, seen);
         chk(req, 32'(seen), 32'(exp), $sformatf("stream bit %0d", k));
         if (k == 0) chk("R2", 32'(drdy_n), 32'd1, "drdy after first fall");
      end
   endtask

   function automatic logic [W-1:0] rand_samples();
      logic [W-1:0] s;
      for (int c = 0; c < NCH; c++) s[c*24 +: 24] = 24'($urandom);
      return s;
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0]   s, sb;
      logic [NCH-1:0] en;
      logic           dyn, seen;
      logic [W-1:0]   st_b;
      int             len_b, prev_end;

      void'($urandom(32'h5EED_0042));
      new_daisy();
      repeat (4) @(negedge clk);
      chk("R1", 32'(dout), 32'd0, "dout after reset");
      chk("R1", 32'(drdy_n), 32'd1, "drdy after reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", 32'(dout), 32'd0, "dout idle");
      chk("R1", 32'(drdy_n), 32'd1, "drdy idle");

      // R11 / R3 / R6: full-scale codes, fixed slots, chain starts at bit 193
      s = rand_samples();
      s[23:0] = 24'h7FFFFF; s[47:24] = 24'h800000;
      do_load(s, '1, 1'b0);
      build(s, '1, 1'b0, cur_st, cur_len);
      chk("R2", 32'(drdy_n), 32'd0, "drdy after load");
      chk("R6", 32'(cur_len), 32'd192, "frame length");
      new_daisy();
      read_range(0, 48, "R11");
      read_range(48, W + 6, "R6");

      // R4: fixed slots with powered-down channels
      s = rand_samples();
      do_load(s, 8'b0110_1010, 1'b0);
      build(s, 8'b0110_1010, 1'b0, cur_st, cur_len);
      new_daisy();
      read_range(0, cur_len + 4, "R4");

      // R5: compacting packing
      s = rand_samples();
      do_load(s, 8'b1010_0101, 1'b1);
      build(s, 8'b1010_0101, 1'b1, cur_st, cur_len);
      chk("R5", 32'(cur_len), 32'd96, "compact length");
      new_daisy();
      read_range(0, cur_len + 6, "R5");

      // R10: inputs changed after load do not alter the frame
      s = rand_samples();
      do_load(s, 8'b1100_0011, 1'b1);
      build(s, 8'b1100_0011, 1'b1, cur_st, cur_len);
      @(negedge clk);
      samples = rand_samples(); chan_en = 8'b0011_1100; pack_dyn = 1'b0;
      new_daisy();
      read_range(0, cur_len + 3, "R10");

      // R7: a load during readback waits for the last local bit
      s = rand_samples();
      do_load(s, '1, 1'b0);
      build(s, '1, 1'b0, cur_st, cur_len);
      new_daisy();
      read_range(0, 30, "R7");
      sb = rand_samples();
      do_load(sb, 8'b0001_0010, 1'b1);
      build(sb, 8'b0001_0010, 1'b1, st_b, len_b);
      chk("R7", 32'(drdy_n), 32'd1, "drdy while frame held");
      read_range(30, cur_len, "R7");
      cur_st = st_b; cur_len = len_b;
      chk("R7", 32'(drdy_n), 32'd0, "drdy after held frame presented");
      new_daisy();
      read_range(0, cur_len + 4, "R7");

      // Random frames in both packing styles
      for (int it = 0; it < 8; it++) begin
         s   = rand_samples();
         en  = NCH'($urandom);
         dyn = 1'($urandom);
         if (it == 0) begin en = 8'b1000_0000; dyn = 1'b1; end
         if (dyn && en == '0) en = 8'b0000_0100;
         do_load(s, en, dyn);
         build(s, en, dyn, cur_st, cur_len);
         chk("R2", 32'(drdy_n), 32'd0, "drdy after random load");
         new_daisy();
         read_range(0, cur_len + 5, dyn ? "R5" : "R4");
      end
      prev_end = cur_len + 5;

      // R8: frame-clock framing
      @(negedge clk);
      fs_mode = 1'b1;
      s = rand_samples();
      do_load(s, 8'b1111_0000, 1'b1);
      chk("R8", 32'(drdy_n), 32'd1, "drdy in frame-clock mode");
      read_range(prev_end, prev_end + 3, "R8");
      clk_bit(dz[prev_end + 4], 1'b1, seen);
      chk("R8", 32'(seen), 32'(dz[prev_end + 3 - cur_len + 1]), "old stream before frame clock");
      build(s, 8'b1111_0000, 1'b1, cur_st, cur_len);
      new_daisy();
      read_range(0, cur_len + 4, "R8");
      chk("R8", 32'(drdy_n), 32'd1, "drdy stays high after frame");
      @(negedge clk);
      fs_mode = 1'b0;

      // R9: settling after resync
      @(negedge clk);
      resync = 1'b1;
      @(negedge clk);
      resync = 1'b0;
      chk("R9", 32'(drdy_n), 32'd1, "drdy after resync");
      for (int n = 0; n < SETTLE; n++) begin
         do_load(rand_samples(), '1, 1'b0);
         chk("R9", 32'(drdy_n), 32'd1, $sformatf("drdy after dropped load %0d", n));
      end
      s = rand_samples();
      do_load(s, '1, 1'b1);
      chk("R9", 32'(drdy_n), 32'd0, "drdy after first accepted load");
      build(s, '1, 1'b1, cur_st, cur_len);
      new_daisy();
      read_range(0, cur_len + 2, "R9");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule